// File: doc/BRIEF.md
# Palette Colour Lookup Register Front End

This block is the host-facing side of a pseudocolour palette. A byte-wide register port exposes four windows, selected by a 2-bit register select: two bytes of a 16-bit internal pointer, a window onto a small file of control bytes, and a window onto the colour palette. The host first places a palette index in the pointer. It then writes red, green and blue bytes one after another to the palette window. After the third byte the whole 24-bit entry is stored at once and the pointer moves to the next entry, so a full table can be loaded in one stream.

Reads of the palette window return the stored components in the same red, green, blue order and advance the pointer in the same way. The control window reaches a file of byte registers placed at a fixed range of pointer values. The first of these is the cursor command byte, which is brought out as a port. On the display side, an 8-bit pixel index is turned into a registered 24-bit colour.

Top module: `pal_dac_regif`

## Requirements
- R1: After reset the pointer is 0x0000, the component phase is red, every palette entry and control byte is zero, and `rgb_out`, `rdata` and `cursor_cmd` are zero.
- R2: A write with `reg_sel` = 0 loads pointer bits 7:0 and `reg_sel` = 1 loads bits 15:8. A read of either select returns that byte one cycle later on `rdata`.
- R3: Any write to either pointer byte returns the component phase to red, even when a colour sequence is part-way done.
- R4: Palette window writes (`reg_sel` = 3) take red, then green, then blue. The entry at index pointer[7:0] changes only on the blue write, when all three bytes are stored together.
- R5: Each third palette-window access (write or read) adds one to the 16-bit pointer, wrapping 0xFFFF to 0x0000.
- R6: A palette-window read returns red, green, then blue of the entry at pointer[7:0] on `rdata` one cycle after the read, advancing the same phase.
- R7: When the pointer is 256 or above, palette-window writes leave the palette unchanged and reads return 0x00, but the phase and pointer still advance.
- R8: Control window (`reg_sel` = 2) accesses reach control byte (pointer − 0x0300) for pointers 0x0300 to 0x030F. Writes outside that range change nothing and reads there return 0x00. Control accesses do not move the pointer.
- R9: `cursor_cmd` always shows control byte 0 (pointer 0x0300). Writing 0x00 there switches the cursor off.
- R10: `rgb_out` equals {red, green, blue} of the entry at `pix_idx` one clock after `pix_idx` is presented.
- R11: When `wr_en` and `rd_en` are high in the same cycle the write is done and the read is dropped: `rdata` holds its value and the phase advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 pointer low, 1 pointer high, 2 control window, 3 palette window |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered, held between reads |
| pix_idx | input | 8 | Pixel palette index |
| rgb_out | output | 24 | Looked-up colour {red, green, blue} |
| cursor_cmd | output | 8 | Cursor command control byte |

## Verification
The assertions assume that each strobe lasts exactly one cycle per access and that `reg_sel` and `wdata` are valid whenever a strobe is high. The bench drives every access from tasks that raise a strobe for one cycle on the falling edge and then lower it. The bench never asks for the pixel index being written in the same cycle, because such a lookup returns the old entry by design. Only the R11 case drives both strobes together, and it does so on purpose.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

  localparam int COMP_W = 8;
  localparam int PTR_W  = 2 * COMP_W;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_CMAP   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] grn;
    logic [COMP_W-1:0] blu;
  } rgb_t;

  function automatic phase_e phase_next(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] ptr_bump(logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [COMP_W-1:0] comp_pick(rgb_t e, phase_e p);
    case (p)
      PH_RED:  return e.red;
      PH_GRN:  return e.grn;
      default: return e.blu;
    endcase
  endfunction

endpackage

// File: rtl/pal_ptr_seq.sv
module pal_ptr_seq
  import pal_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [COMP_W-1:0] wdata,
  input  logic              cmap_step,
  output logic [PTR_W-1:0]  ptr,
  output phase_e            phase,
  output logic              last_step
);

  assign last_step = cmap_step && (phase == PH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= PH_RED;
    end else if (lo_we) begin
      ptr[COMP_W-1:0] <= wdata;
      phase           <= PH_RED;
    end else if (hi_we) begin
      ptr[PTR_W-1:COMP_W] <= wdata;
      phase               <= PH_RED;
    end else if (cmap_step) begin
      phase <= phase_next(phase);
      if (phase == PH_BLU) ptr <= ptr_bump(ptr);
    end
  end

  assert_phase_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we || hi_we) |=> (phase == PH_RED));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !lo_we && !hi_we) |=> (ptr == $past(ptr) + 16'd1));

  assert_phase_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  assert_ptr_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_we && !hi_we && !last_step) |=> $stable(ptr));

endmodule

// File: rtl/pal_color_ram.sv
module pal_color_ram
  import pal_dac_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmap_we,
  input  phase_e            phase,
  input  logic [COMP_W-1:0] wdata,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [IDX_W-1:0]  pix_idx,
  output rgb_t              rgb_out,
  output logic [COMP_W-1:0] cmap_rdata,
  output logic              commit
);

  rgb_t              mem [DEPTH];
  logic [COMP_W-1:0] stg_red;
  logic [COMP_W-1:0] stg_grn;
  logic              in_range;
  logic [IDX_W-1:0]  wr_idx;

  assign in_range   = (ptr < PTR_W'(DEPTH));
  assign wr_idx     = ptr[IDX_W-1:0];
  assign commit     = cmap_we && in_range && (phase == PH_BLU);
  assign cmap_rdata = in_range ? comp_pick(mem[wr_idx], phase) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_red <= '0;
      stg_grn <= '0;
    end else if (cmap_we) begin
      if (phase == PH_RED) stg_red <= wdata;
      if (phase == PH_GRN) stg_grn <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (commit) begin
      mem[wr_idx] <= '{red: stg_red, grn: stg_grn, blu: wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_out <= '0;
    else        rgb_out <= mem[pix_idx];
  end

  assert_commit_on_blue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (phase == PH_BLU) && cmap_we);

  assert_no_commit_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr[PTR_W-1:IDX_W] != '0) |-> !commit);

  assert_high_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr[PTR_W-1:IDX_W] != '0) |-> (cmap_rdata == '0));

endmodule

// File: rtl/pal_ctrl_file.sv
module pal_ctrl_file
  import pal_dac_pkg::*;
#(
  parameter logic [15:0] BASE  = 16'h0300,
  parameter int          DEPTH = 16,
  localparam int         OFS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [COMP_W-1:0] wdata,
  output logic [COMP_W-1:0] rdata,
  output logic [COMP_W-1:0] cursor_cmd
);

  logic [PTR_W-1:0]  ofs_full;
  logic              hit;
  logic [OFS_W-1:0]  ofs;
  logic [COMP_W-1:0] regs [DEPTH];

  assign ofs_full = ptr - BASE;
  assign hit      = (ofs_full < PTR_W'(DEPTH));
  assign ofs      = ofs_full[OFS_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                              regs[g] <= '0;
      else if (we && hit && (ofs == OFS_W'(g))) regs[g] <= wdata;
    end
  end

  assign rdata      = hit ? regs[ofs] : '0;
  assign cursor_cmd = regs[0];

  assert_cursor_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (ptr == BASE)) |=> (cursor_cmd == $past(wdata)));

  assert_cursor_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (ptr == BASE)) |=> $stable(cursor_cmd));

  assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0));

endmodule

// File: rtl/pal_dac_regif.sv
module pal_dac_regif
  import pal_dac_pkg::*;
#(
  parameter int          PAL_DEPTH  = 256,
  parameter logic [15:0] CTRL_BASE  = 16'h0300,
  parameter int          CTRL_DEPTH = 16,
  localparam int         IDX_W      = $clog2(PAL_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          reg_sel,
  input  logic [COMP_W-1:0]   wdata,
  output logic [COMP_W-1:0]   rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] rgb_out,
  output logic [COMP_W-1:0]   cursor_cmd
);

  reg_sel_e          sel;
  logic              rd_go;
  logic              lo_we, hi_we, ctrl_we, cmap_we, cmap_step;
  logic [PTR_W-1:0]  ptr;
  phase_e            phase;
  logic              last_step;
  logic              commit;
  logic [COMP_W-1:0] cmap_rdata;
  logic [COMP_W-1:0] ctrl_rdata;
  rgb_t              rgb_q;

  assign sel       = reg_sel_e'(reg_sel);
  assign rd_go     = rd_en && !wr_en;
  assign lo_we     = wr_en && (sel == SEL_PTR_LO);
  assign hi_we     = wr_en && (sel == SEL_PTR_HI);
  assign ctrl_we   = wr_en && (sel == SEL_CTRL);
  assign cmap_we   = wr_en && (sel == SEL_CMAP);
  assign cmap_step = (wr_en || rd_go) && (sel == SEL_CMAP);

  pal_ptr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .wdata     (wdata),
    .cmap_step (cmap_step),
    .ptr       (ptr),
    .phase     (phase),
    .last_step (last_step)
  );

  pal_color_ram #(.DEPTH(PAL_DEPTH)) u_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmap_we    (cmap_we),
    .phase      (phase),
    .wdata      (wdata),
    .ptr        (ptr),
    .pix_idx    (pix_idx),
    .rgb_out    (rgb_q),
    .cmap_rdata (cmap_rdata),
    .commit     (commit)
  );

  pal_ctrl_file #(.BASE(CTRL_BASE), .DEPTH(CTRL_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (ctrl_we),
    .ptr        (ptr),
    .wdata      (wdata),
    .rdata      (ctrl_rdata),
    .cursor_cmd (cursor_cmd)
  );

  assign rgb_out = rgb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_go) begin
      case (sel)
        SEL_PTR_LO: rdata <= ptr[COMP_W-1:0];
        SEL_PTR_HI: rdata <= ptr[PTR_W-1:COMP_W];
        SEL_CTRL:   rdata <= ctrl_rdata;
        default:    rdata <= cmap_rdata;
      endcase
    end
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));

  assert_commit_then_red_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (phase == PH_RED));

  assert_ctrl_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2) |=> $stable(ptr));

endmodule

// File: tb/pal_dac_regif_bench.sv
module pal_dac_regif_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] rgb_out;
  logic [7:0]  cursor_cmd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pal_dac_regif u_pal_dac_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .pix_idx(pix_idx), .rgb_out(rgb_out), .cursor_cmd(cursor_cmd)
  );

  function automatic logic [23:0] colour(int i, int pass);
    logic [7:0] b = 8'(i);
    return {b * 8'd7 + 8'd3, b ^ 8'hC3, ~b + 8'(pass)};
  endfunction

  task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_ptr(logic [15:0] p);
    bus_wr(2'd0, p[7:0]);
    bus_wr(2'd1, p[15:8]);
  endtask

  task automatic look(logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    c = rgb_out;
  endtask

  initial begin
    logic [7:0]  rb, gb, bb;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", {16'd0, rdata}, 24'd0);
    check("R1 rgb_out", rgb_out, 24'd0);
    check("R1 cursor_cmd", {16'd0, cursor_cmd}, 24'd0);
    look(8'd77, c);
    check("R1 palette zero", c, 24'd0);
    bus_rd(2'd0, rb); bus_rd(2'd1, gb);
    check("R1 ptr zero", {8'd0, gb, rb}, 24'd0);

    // R4/R5: stream all entries from index 0
    set_ptr(16'h0000);
    for (int i = 0; i < 256; i++) begin
      c = colour(i, 0);
      bus_wr(2'd3, c[23:16]); bus_wr(2'd3, c[15:8]); bus_wr(2'd3, c[7:0]);
    end
    bus_rd(2'd0, rb); bus_rd(2'd1, gb);
    check("R2 R5 ptr after stream", {8'd0, gb, rb}, 24'h000100);

    // R10: every index looked up
    for (int i = 0; i < 256; i++) begin
      look(8'(i), c);
      check("R10 R4 lookup", c, colour(i, 0));
    end

    // R6: read back in R,G,B order
    set_ptr(16'h0000);
    for (int i = 0; i < 256; i++) begin
      bus_rd(2'd3, rb); bus_rd(2'd3, gb); bus_rd(2'd3, bb);
      check("R6 readback", {rb, gb, bb}, colour(i, 0));
    end
    bus_rd(2'd0, rb); bus_rd(2'd1, gb);
    check("R5 ptr after read stream", {8'd0, gb, rb}, 24'h000100);

    // R4/R3: partial sequence, then restart
    set_ptr(16'h0005);
    bus_wr(2'd3, 8'h11); bus_wr(2'd3, 8'h22);
    look(8'd5, c);
    check("R4 no commit before blue", c, colour(5, 0));
    bus_wr(2'd0, 8'h05);
    bus_wr(2'd3, 8'hA1); bus_wr(2'd3, 8'hB2); bus_wr(2'd3, 8'hC3);
    look(8'd5, c);
    check("R3 phase restart", c, 24'hA1B2C3);
    bus_wr(2'd3, 8'h44);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h06);
    bus_wr(2'd3, 8'h01); bus_wr(2'd3, 8'h02); bus_wr(2'd3, 8'h03);
    look(8'd6, c);
    check("R3 high write restarts phase", c, 24'h010203);

    // R5/R7: wrap from 0xFFFF, no palette change
    set_ptr(16'hFFFF);
    bus_wr(2'd3, 8'h9A); bus_wr(2'd3, 8'h9B); bus_wr(2'd3, 8'h9C);
    bus_rd(2'd0, rb); bus_rd(2'd1, gb);
    check("R5 wrap to zero", {8'd0, gb, rb}, 24'd0);
    look(8'hFF, c);
    check("R7 high ptr no write", c, colour(255, 0));
    set_ptr(16'h0102);
    bus_rd(2'd3, rb); bus_rd(2'd3, gb); bus_rd(2'd3, bb);
    check("R7 high ptr reads zero", {rb, gb, bb}, 24'd0);
    bus_rd(2'd0, rb);
    check("R7 ptr still advances", {16'd0, rb}, 24'h000003);

    // R8/R9: control window
    set_ptr(16'h0300);
    bus_wr(2'd2, 8'hA5);
    @(negedge clk);
    check("R9 cursor set", {16'd0, cursor_cmd}, 24'h0000A5);
    bus_rd(2'd2, rb);
    check("R8 ctrl read 0", {16'd0, rb}, 24'h0000A5);
    bus_wr(2'd2, 8'h00);
    @(negedge clk);
    check("R9 cursor off", {16'd0, cursor_cmd}, 24'd0);
    bus_wr(2'd2, 8'h5E);
    set_ptr(16'h030F);
    bus_wr(2'd2, 8'h3C);
    bus_rd(2'd2, rb);
    check("R8 ctrl last slot", {16'd0, rb}, 24'h00003C);
    bus_rd(2'd0, gb);
    check("R8 ptr not moved", {16'd0, gb}, 24'h00000F);
    set_ptr(16'h0310);
    bus_wr(2'd2, 8'h77);
    bus_rd(2'd2, rb);
    check("R8 out of range reads zero", {16'd0, rb}, 24'd0);
    set_ptr(16'h02FF);
    bus_wr(2'd2, 8'h66);
    bus_rd(2'd2, rb);
    check("R8 below base reads zero", {16'd0, rb}, 24'd0);
    check("R8 R9 cursor untouched", {16'd0, cursor_cmd}, 24'h00005E);
    set_ptr(16'h0001);
    bus_rd(2'd3, rb);
    check("R8 miss left palette intact", {16'd0, rb}, {16'd0, colour(1, 0) >> 16});

    // R11: simultaneous write and read
    set_ptr(16'h0010);
    bus_rd(2'd0, rb);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; reg_sel = 2'd3; wdata = 8'hD1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 rdata held", {16'd0, rdata}, 24'h000010);
    bus_wr(2'd3, 8'hD2); bus_wr(2'd3, 8'hD3);
    look(8'h10, c);
    check("R11 single phase step", c, 24'hD1D2D3);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule